// File: doc/BRIEF.md
# Three-Level Upper-Switch Threshold Mapper with Triangle Carrier

This block turns one modulation cycle's worth of switching decisions for a three-level inverter into gate signals for the two upper switches of each phase. A modulator upstream supplies an ordered sequence of four switching steps. In that sequence the short vector appears twice, once at the start and once at the end. The modulator also supplies three dwell times and the carrier period. For every upper switch the block counts how many of the four steps leave that switch off. That count selects one compare threshold from the period, zero, or one of three cumulative boundaries, where the first boundary holds half of the short-vector dwell time.

The block contains its own triangle carrier, an up/down counter. Newly accepted thresholds and a new period wait in a holding register. They become active only at a carrier turnaround (peak or valley), so a switch edge never moves within a half period. Each gate output is registered and is high while the carrier is below that switch's active threshold.

The sequence input is a valid/ready stream that never applies back-pressure. `in_ready` is always high, every cycle with `in_valid` high is a transfer, and the most recent transfer before a turnaround is the one that takes effect.

Top module: `svm_thr_mapper`

## Requirements
- R1: `in_ready` is high in every cycle after reset. A cycle with `in_valid` high captures `in_seq`, `in_ta`, `in_tb`, `in_tc` and `in_ts` into the holding register, and a later capture replaces an earlier one that has not yet been applied.
- R2: Step i of the sequence for phase p (A=0, B=1, C=2) is `in_seq[(3*i+p)*2 +: 2]`, with step 0 first. Level 0 maps to upper-switch pattern 00, level 1 to 01, and level 2 or the unused code 3 to 11. Pattern bit 1 is the outer switch and bit 0 is the inner switch, and 1 means on.
- R3: The boundaries are b1 = floor(ta/2), b2 = b1 + tb and b3 = b2 + tc. b2 and b3 each saturate at 65535, and b3 is built from the saturated b2.
- R4: For switch k = 2*p + j (j=0 outer, j=1 inner), let z be the number of steps in which that switch is off. The threshold is ts when z=0, b1 when z=1, b2 when z=2, b3 when z=3 and 0 when z=4. It is reported on `thr_out[16*k +: 16]`.
- R5: `thr_out` changes only in the cycle after a cycle in which `carrier_turn` is high. At that edge it takes the content of the holding register.
- R6: The carrier counts up by one from 0 to top and back down by one to 0, where top = ts-1 (top = 0 when ts = 0). `carrier_turn` is high in the cycle where the carrier is at its peak (rising and at or above top) or at its valley (falling and at 0). A new top is taken from the holding register at each turnaround. Leaving the valley, the carrier moves to 1, or stays at 0 if the new top is 0.
- R7: Each bit of `gate_out` in cycle t+1 equals (carrier < threshold) in cycle t for its switch. A zero threshold keeps the gate low, and a threshold of at least ts keeps it high.
- R8: During reset the carrier, all thresholds and all gates are 0 and `carrier_turn` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sequence and times valid |
| in_ready | output | 1 | Always high after reset; no back-pressure |
| in_seq | input | 24 | Four steps x three phases x 2-bit level |
| in_ta | input | 16 | Short-vector dwell time (split in half) |
| in_tb | input | 16 | Second dwell time |
| in_tc | input | 16 | Third dwell time |
| in_ts | input | 16 | Carrier period (peak = ts-1) |
| thr_out | output | 96 | Six active thresholds, switch k at [16k +: 16] |
| gate_out | output | 6 | Registered upper-switch gate signals |
| carrier | output | 16 | Triangle carrier count |
| carrier_turn | output | 1 | High at carrier peak and valley |

## Verification
A wrong zero count or boundary sum shows up at the first turnaround after a load: one slice of `thr_out` then holds the wrong value. One cycle later the matching gate is high for the wrong number of carrier steps. A fault in the direction or top register shows within one half period, as a carrier that skips a value, passes its peak, or raises `carrier_turn` in the wrong cycle. A threshold that updates outside a turnaround is visible in the very cycle it occurs. The bench drives directed sequences with known literal thresholds, saturating dwell times, a zero period and seeded random loads placed anywhere in the carrier period. It compares every output in every cycle against a model computed from the requirements.

// File: rtl/svm_thr_pkg.sv
package svm_thr_pkg;
  localparam int NSTEP = 4;
  localparam int NPH   = 3;
  localparam int NSW   = 2 * NPH;
  localparam int LVW   = 2;
  localparam int SEQW  = NSTEP * NPH * LVW;

  // level -> {outer, inner} upper-switch on pattern
  function automatic logic [1:0] lvl_pattern(input logic [LVW-1:0] lv);
    case (lv)
      2'd0:    lvl_pattern = 2'b00;
      2'd1:    lvl_pattern = 2'b01;
      default: lvl_pattern = 2'b11;
    endcase
  endfunction
endpackage

// File: rtl/thr_map.sv
module thr_map
  import svm_thr_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic [SEQW-1:0]   seq,
  input  logic [TW-1:0]     ta,
  input  logic [TW-1:0]     tb,
  input  logic [TW-1:0]     tc,
  input  logic [TW-1:0]     ts,
  output logic [NSW*TW-1:0] thr
);
  logic [TW:0]   sum2, sum3;
  logic [TW-1:0] bnd1, bnd2, bnd3;

  assign bnd1 = ta >> 1;
  assign sum2 = {1'b0, bnd1} + {1'b0, tb};
  assign bnd2 = sum2[TW] ? {TW{1'b1}} : sum2[TW-1:0];
  assign sum3 = {1'b0, bnd2} + {1'b0, tc};
  assign bnd3 = sum3[TW] ? {TW{1'b1}} : sum3[TW-1:0];

  for (genvar p = 0; p < NPH; p++) begin : g_ph
    for (genvar j = 0; j < 2; j++) begin : g_sw
      logic [2:0] zc;
      always_comb begin
        zc = '0;
        for (int i = 0; i < NSTEP; i++) begin
          if (!lvl_pattern(seq[(i*NPH+p)*LVW +: LVW])[1-j]) zc = zc + 3'd1;
        end
      end
      always_comb begin
        case (zc)
          3'd0:    thr[(2*p+j)*TW +: TW] = ts;
          3'd1:    thr[(2*p+j)*TW +: TW] = bnd1;
          3'd2:    thr[(2*p+j)*TW +: TW] = bnd2;
          3'd3:    thr[(2*p+j)*TW +: TW] = bnd3;
          default: thr[(2*p+j)*TW +: TW] = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/tri_carrier.sv
module tri_carrier #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] pend_top,
  output logic [TW-1:0] cnt,
  output logic          turn
);
  logic          rising;
  logic [TW-1:0] top_q;

  assign turn = rising ? (cnt >= top_q) : (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      rising <= 1'b1;
      top_q  <= '0;
    end else if (turn) begin
      top_q <= pend_top;
      if (rising) begin
        rising <= 1'b0;
        cnt    <= (cnt == '0) ? '0 : cnt - 1'b1;
      end else begin
        rising <= 1'b1;
        cnt    <= (pend_top == '0) ? '0 : {{(TW-1){1'b0}}, 1'b1};
      end
    end else begin
      cnt <= rising ? cnt + 1'b1 : cnt - 1'b1;
    end
  end

  // R6
  carrier_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !turn |=> ((cnt == $past(cnt) + 1'b1) || (cnt + 1'b1 == $past(cnt))));

  // R6
  carrier_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rising |-> (cnt <= top_q));
endmodule

// File: rtl/gate_cmp.sv
module gate_cmp #(
  parameter int TW  = 16,
  parameter int NSW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TW-1:0]     cnt,
  input  logic [NSW*TW-1:0] thr,
  output logic [NSW-1:0]    gate
);
  for (genvar k = 0; k < NSW; k++) begin : g_cmp
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) gate[k] <= 1'b0;
      else        gate[k] <= (cnt < thr[k*TW +: TW]);
    end

    // R7
    gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (thr[k*TW +: TW] == '0) |=> !gate[k]);
  end
endmodule

// File: rtl/svm_thr_mapper.sv
module svm_thr_mapper
  import svm_thr_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [SEQW-1:0]   in_seq,
  input  logic [TW-1:0]     in_ta,
  input  logic [TW-1:0]     in_tb,
  input  logic [TW-1:0]     in_tc,
  input  logic [TW-1:0]     in_ts,
  output logic [NSW*TW-1:0] thr_out,
  output logic [NSW-1:0]    gate_out,
  output logic [TW-1:0]     carrier,
  output logic              carrier_turn
);
  logic [NSW*TW-1:0] map_thr, pend_thr, act_thr;
  logic [TW-1:0]     pend_top;

  assign in_ready = rst_n;

  thr_map #(.TW(TW)) u_map (
    .seq(in_seq), .ta(in_ta), .tb(in_tb), .tc(in_tc), .ts(in_ts), .thr(map_thr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_thr <= '0;
      pend_top <= '0;
      act_thr  <= '0;
    end else begin
      if (in_valid) begin
        pend_thr <= map_thr;
        pend_top <= (in_ts == '0) ? '0 : in_ts - 1'b1;
      end
      if (carrier_turn) act_thr <= pend_thr;
    end
  end

  assign thr_out = act_thr;

  tri_carrier #(.TW(TW)) u_car (
    .clk(clk), .rst_n(rst_n), .pend_top(pend_top), .cnt(carrier), .turn(carrier_turn)
  );

  gate_cmp #(.TW(TW), .NSW(NSW)) u_gate (
    .clk(clk), .rst_n(rst_n), .cnt(carrier), .thr(act_thr), .gate(gate_out)
  );

  // R5
  thr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !carrier_turn |=> $stable(act_thr));
endmodule

// File: tb/sim_svm_thr_mapper.sv
module sim_svm_thr_mapper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [23:0] in_seq = '0;
  logic [15:0] in_ta = '0, in_tb = '0, in_tc = '0, in_ts = '0;
  logic [95:0] thr_out;
  logic [5:0]  gate_out;
  logic [15:0] carrier;
  logic        carrier_turn;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  svm_thr_mapper u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_seq(in_seq), .in_ta(in_ta), .in_tb(in_tb), .in_tc(in_tc), .in_ts(in_ts),
    .thr_out(thr_out), .gate_out(gate_out), .carrier(carrier), .carrier_turn(carrier_turn)
  );

  // model state
  int          m_cnt, m_top, m_ptop;
  bit          m_up;
  logic [15:0] m_pthr [6];
  logic [15:0] m_athr [6];
  bit          m_gate [6];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int sat16(input int v);
    return (v > 65535) ? 65535 : v;
  endfunction

  // R2 R3 R4 expected threshold of switch k
  function automatic logic [15:0] exp_thr(input logic [23:0] sq, input int ta, input int tb,
                                          input int tc, input int ts, input int k);
    int p = k / 2;
    int j = k % 2;
    int z = 0;
    int b1 = ta / 2;
    int b2 = sat16(b1 + tb);
    int b3 = sat16(b2 + tc);
    for (int i = 0; i < 4; i++) begin
      int lv = int'(sq[(3*i+p)*2 +: 2]);
      bit on = (j == 0) ? (lv >= 2) : (lv >= 1);
      if (!on) z++;
    end
    case (z)
      0: return 16'(ts);
      1: return 16'(b1);
      2: return 16'(b2);
      3: return 16'(b3);
      default: return 16'd0;
    endcase
  endfunction

  task automatic cyc();
    bit          turn_m;
    int          n_cnt, n_top, n_ptop;
    bit          n_up;
    logic [15:0] n_pthr [6];
    logic [15:0] n_athr [6];
    bit          n_gate [6];
    turn_m = m_up ? (m_cnt >= m_top) : (m_cnt == 0);
    n_ptop = m_ptop; n_top = m_top; n_up = m_up;
    for (int k = 0; k < 6; k++) begin
      n_gate[k] = (m_cnt < int'(m_athr[k]));
      n_pthr[k] = m_pthr[k];
      n_athr[k] = turn_m ? m_pthr[k] : m_athr[k];
    end
    if (in_valid) begin
      for (int k = 0; k < 6; k++)
        n_pthr[k] = exp_thr(in_seq, int'(in_ta), int'(in_tb), int'(in_tc), int'(in_ts), k);
      n_ptop = (in_ts == 0) ? 0 : int'(in_ts) - 1;
    end
    if (turn_m) begin
      n_top = m_ptop;
      if (m_up) begin n_up = 1'b0; n_cnt = (m_cnt == 0) ? 0 : m_cnt - 1; end
      else begin n_up = 1'b1; n_cnt = (m_ptop == 0) ? 0 : 1; end
    end else begin
      n_cnt = m_up ? m_cnt + 1 : m_cnt - 1;
    end
    @(posedge clk);
    m_cnt = n_cnt; m_top = n_top; m_ptop = n_ptop; m_up = n_up;
    for (int k = 0; k < 6; k++) begin
      m_pthr[k] = n_pthr[k]; m_athr[k] = n_athr[k]; m_gate[k] = n_gate[k];
    end
    @(negedge clk);
    chk(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
    chk(int'(carrier) == m_cnt, "R6 carrier", int'(carrier), m_cnt);
    turn_m = m_up ? (m_cnt >= m_top) : (m_cnt == 0);
    chk(carrier_turn == turn_m, "R6 turn", int'(carrier_turn), int'(turn_m));
    for (int k = 0; k < 6; k++) begin
      chk(thr_out[16*k +: 16] == m_athr[k], "R5 threshold", int'(thr_out[16*k +: 16]), int'(m_athr[k]));
      chk(gate_out[k] == m_gate[k], "R7 gate", int'(gate_out[k]), int'(m_gate[k]));
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic load(input logic [23:0] sq, input int ta, input int tb, input int tc, input int ts);
    in_seq = sq; in_ta = 16'(ta); in_tb = 16'(tb); in_tc = 16'(tc); in_ts = 16'(ts);
    in_valid = 1'b1;
    cyc();
    in_valid = 1'b0;
  endtask

  function automatic logic [23:0] pack(input int s0a, input int s0b, input int s0c,
                                       input int s1a, input int s1b, input int s1c,
                                       input int s2a, input int s2b, input int s2c,
                                       input int s3a, input int s3b, input int s3c);
    logic [23:0] r;
    r = {2'(s3c), 2'(s3b), 2'(s3a), 2'(s2c), 2'(s2b), 2'(s2a),
         2'(s1c), 2'(s1b), 2'(s1a), 2'(s0c), 2'(s0b), 2'(s0a)};
    return r;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      errors++;
      $display("FAIL R6 watchdog actual=%0d expected=%0d", cycles, 200000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [23:0] ex;
    void'($urandom(32'd1234));
    m_cnt = 0; m_top = 0; m_ptop = 0; m_up = 1'b1;
    for (int k = 0; k < 6; k++) begin m_pthr[k] = '0; m_athr[k] = '0; m_gate[k] = 1'b0; end

    repeat (3) @(negedge clk);
    // R8 reset state
    chk(carrier == 16'd0, "R8 carrier", int'(carrier), 0);
    chk(carrier_turn == 1'b1, "R8 turn", int'(carrier_turn), 1);
    chk(thr_out == '0, "R8 thresholds", int'(thr_out[15:0]), 0);
    chk(gate_out == '0, "R8 gates", int'(gate_out), 0);
    rst_n = 1'b1;
    run(4);

    // R2 R4 directed: steps (1,0,0) (2,0,0) (2,1,0) (2,1,1)
    ex = pack(1,0,0, 2,0,0, 2,1,0, 2,1,1);
    load(ex, 10, 12, 8, 40);
    run(120);
    chk(thr_out[15:0]  == 16'd5,  "R4 A outer z1", int'(thr_out[15:0]), 5);
    chk(thr_out[31:16] == 16'd40, "R4 A inner z0", int'(thr_out[31:16]), 40);
    chk(thr_out[47:32] == 16'd0,  "R4 B outer z4", int'(thr_out[47:32]), 0);
    chk(thr_out[63:48] == 16'd17, "R3 B inner z2", int'(thr_out[63:48]), 17);
    chk(thr_out[79:64] == 16'd0,  "R4 C outer z4", int'(thr_out[79:64]), 0);
    chk(thr_out[95:80] == 16'd25, "R3 C inner z3", int'(thr_out[95:80]), 25);

    // R3 saturation, R2 unused code 3 treated as level 2
    load(pack(1,0,0, 3,0,0, 3,1,0, 3,1,1), 65535, 65535, 5, 30);
    run(80);
    chk(thr_out[15:0]  == 16'd32767, "R3 half split", int'(thr_out[15:0]), 32767);
    chk(thr_out[63:48] == 16'd65535, "R3 b2 saturate", int'(thr_out[63:48]), 65535);
    chk(thr_out[95:80] == 16'd65535, "R3 b3 saturate", int'(thr_out[95:80]), 65535);

    // R6 zero period
    load(ex, 4, 4, 4, 0);
    run(20);
    chk(carrier == 16'd0, "R6 zero period carrier", int'(carrier), 0);

    // R1 R5 back-to-back loads: last one wins
    load(ex, 6, 6, 6, 20);
    load(pack(0,0,0, 1,1,1, 2,2,2, 2,2,1), 2, 3, 4, 20);
    run(60);

    // random loads at random positions in the period
    for (int n = 0; n < 60; n++) begin
      logic [23:0] sq;
      sq = 24'($urandom);
      load(sq, int'($urandom_range(0, 50)), int'($urandom_range(0, 40)),
           int'($urandom_range(0, 40)), int'($urandom_range(0, 60)));
      run(int'($urandom_range(1, 90)));
    end
    run(150);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule